// File: doc/BRIEF.md
# Cipher Engine Command Sequencer

This block sits between a host and a block-cipher engine. The host writes 32-bit command words into a small input queue. The sequencer takes them from the queue in order and turns each one into a control action: it sets up an input transfer, starts a run of cipher blocks, signals that a transfer is complete, loads a key table into an internal slot, or starts a bulk word copy between external memory and the engine's internal RAM. Commands that need an address take the next queued word as that operand.

The cipher datapath, the memory bus and the internal RAM are outside this block. Single-cycle strobes with decoded fields stand in for them. Two timers model how long a block run and a word copy take, and they drive the engine-busy and copy-busy status outputs. Events are recorded in an interrupt status register. The host clears its bits by writing ones to them, and an enable mask decides which bits drive the interrupt line.

Top module: `cipher_cmd_sequencer`

## Requirements
- R1: The queue holds up to 5 words and its empty state is visible on `q_empty`. A write is accepted only when the queue is not full and either the engine is idle or the queue is empty. Any other write is dropped and sets status bit 1.
- R2: The opcode is held in bits [31:26]. A DMA-setup command (0x10) treats the next queued word as an address, even if that word looks like a command. It pulses `setup_stb` with that word on `setup_addr`.
- R3: A start command (0x0E) carries the block count minus one in bits [CNT_W-1:0]. It is taken only while the engine is idle. `eng_busy` then stays high for exactly (count+1)*BLK_CYCLES cycles, and status bit 4 is set when the run ends.
- R4: A transfer-complete command (0x11) waits in the queue while the engine is busy. It then produces exactly one `xfer_done_stb` pulse.
- R5: A copy command (0x22) takes its direction from bit 25 (0 means external to internal) and its word count from bits [24:12]. The next queued word is the external address. It waits while a copy is in progress. `dma_busy` stays high for max(count,1) cycles, and status bit 5 is set when the copy ends.
- R6: A table-load command (0x15) places the table select in bits [25:24], the RAM select in bit 23 and a 4-bit key-table id in bits [20:17]. A valid id has bit 20 set and the slot number in bits [19:17]. A valid load pulses `tbl_stb`. An id without bit 20 is dropped and sets status bit 0. Table loads wait while a copy is in progress.
- R7: An unknown opcode is dropped and sets status bit 0. The commands that follow it still execute.
- R8: Writing a mask to the clear port clears the status bits where the mask has ones. Writing 0xFF clears every bit.
- R9: `irq` is the OR of status ANDed with the enable mask. The mask resets to 0. A mask of 0x33 enables bits 0, 1, 4 and 5.
- R10: After reset the status is zero, the queue is empty, both busy flags are low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write the command word into the queue |
| cmd_word | input | 32 | Command or operand word |
| int_en_wr | input | 1 | Load the interrupt enable mask |
| int_en_val | input | 8 | New enable mask |
| int_clr_wr | input | 1 | Clear status bits (write one to clear) |
| int_clr_val | input | 8 | Mask of bits to clear |
| int_status | output | 8 | Status: 0 bad command, 1 rejected write, 4 run done, 5 copy done |
| irq | output | 1 | Interrupt line |
| eng_busy | output | 1 | A block run is in progress |
| q_empty | output | 1 | Queue holds no words |
| dma_busy | output | 1 | A word copy is in progress |
| setup_stb | output | 1 | Transfer setup pulse |
| setup_addr | output | 32 | Input buffer address |
| run_stb | output | 1 | Block run start pulse |
| run_blocks_m1 | output | CNT_W (12) | Block count minus one |
| xfer_done_stb | output | 1 | Transfer complete pulse |
| tbl_stb | output | 1 | Key table load pulse |
| tbl_sel | output | 2 | Table select |
| tbl_ram_sel | output | 1 | RAM select |
| tbl_slot | output | 3 | Key slot number |
| copy_stb | output | 1 | Word copy start pulse |
| copy_dir | output | 1 | Copy direction |
| copy_words | output | 13 | Copy word count |
| copy_addr | output | 32 | External address of the copy |

## Verification
The hardest state to reach from the ports is a full queue. The sequencer removes one word per cycle whenever it can. The write rule also blocks filling the queue while a block run is active. To get there, the bench first starts a long word copy. It then writes table-load commands, which stall behind the copy while the engine stays idle, so the queue fills to five. A sixth write must be rejected, and exactly five loads must drain afterwards. A second case makes the busy-and-not-empty rejection happen: a long run is started, a transfer-complete command is queued behind it, and one more word is written.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [5:0] {
    OP_START = 6'h0E,
    OP_SETUP = 6'h10,
    OP_XDONE = 6'h11,
    OP_TABLE = 6'h15,
    OP_COPY  = 6'h22
  } op_e;

  localparam int IRQ_W        = 8;
  localparam int IB_BADCMD    = 0;
  localparam int IB_REJECT    = 1;
  localparam int IB_RUN       = 4;
  localparam int IB_COPY      = 5;

  localparam int OPC_LSB      = 26;
  localparam int COPY_DIR_BIT = 25;
  localparam int COPY_CNT_LSB = 12;
  localparam int COPY_CNT_W   = 13;
  localparam int TBL_SEL_LSB  = 24;
  localparam int TBL_RAM_BIT  = 23;
  localparam int KEY_ID_LSB   = 17;
endpackage

// File: rtl/ccs_fifo.sv
module ccs_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  // storage without reset so the array maps onto RAM
  always_ff @(posedge clk)
    if (push) mem[wp] <= din;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  p_push_room_r1: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  p_pop_data_r1:  assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/ccs_run_timer.sv
module ccs_run_timer #(
  parameter int CNT_W      = 12,
  parameter int BLK_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] blocks_m1,
  output logic             busy,
  output logic             done
);
  localparam int BW = (BLK_CYCLES > 1) ? $clog2(BLK_CYCLES) : 1;

  logic [CNT_W-1:0] rem;
  logic [BW-1:0]    beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      rem  <= '0;
      beat <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        rem  <= blocks_m1;
        beat <= BW'(BLK_CYCLES - 1);
      end else if (busy) begin
        if (beat == '0) begin
          if (rem == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            rem  <= rem - 1'b1;
            beat <= BW'(BLK_CYCLES - 1);
          end
        end else begin
          beat <= beat - 1'b1;
        end
      end
    end
  end

  p_start_idle_r3: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
  p_done_end_r3:   assert property (@(posedge clk) disable iff (rst) done |-> !busy && $past(busy));
endmodule

// File: rtl/ccs_copy_timer.sv
module ccs_copy_timer #(
  parameter int WCNT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WCNT_W-1:0] words,
  output logic              busy,
  output logic              done
);
  logic [WCNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= (words == '0) ? WCNT_W'(1) : words;
      end else if (busy) begin
        if (cnt == WCNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_copy_start_idle_r5: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
  p_copy_done_end_r5:   assert property (@(posedge clk) disable iff (rst) done |-> !busy && $past(busy));
endmodule

// File: rtl/cipher_cmd_sequencer.sv
module cipher_cmd_sequencer
  import ccs_pkg::*;
#(
  parameter int DEPTH      = 5,
  parameter int CNT_W      = 12,
  parameter int BLK_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_wr,
  input  logic [31:0]           cmd_word,
  input  logic                  int_en_wr,
  input  logic [IRQ_W-1:0]      int_en_val,
  input  logic                  int_clr_wr,
  input  logic [IRQ_W-1:0]      int_clr_val,
  output logic [IRQ_W-1:0]      int_status,
  output logic                  irq,
  output logic                  eng_busy,
  output logic                  q_empty,
  output logic                  dma_busy,
  output logic                  setup_stb,
  output logic [31:0]           setup_addr,
  output logic                  run_stb,
  output logic [CNT_W-1:0]      run_blocks_m1,
  output logic                  xfer_done_stb,
  output logic                  tbl_stb,
  output logic [1:0]            tbl_sel,
  output logic                  tbl_ram_sel,
  output logic [2:0]            tbl_slot,
  output logic                  copy_stb,
  output logic                  copy_dir,
  output logic [COPY_CNT_W-1:0] copy_words,
  output logic [31:0]           copy_addr
);
  localparam int HDR_W = COPY_CNT_W + 1;

  typedef enum logic {S_CMD, S_OPND} st_e;

  logic [31:0]      head;
  logic             q_full, accept, reject, pop;
  st_e              state, nxt_state;
  logic             pend_copy;
  logic [HDR_W-1:0] pend_hdr;
  logic [5:0]       opc;
  logic             run_go, copy_go, setup_go, xdone_go, tbl_go, bad_go;
  logic             run_done, copy_done;
  logic [IRQ_W-1:0] en_q, set_vec, status_nxt, en_nxt;

  assign accept = cmd_wr && !q_full && (!eng_busy || q_empty);
  assign reject = cmd_wr && !accept;

  ccs_fifo #(.DW(32), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(accept), .din(cmd_word),
    .pop(pop), .dout(head), .empty(q_empty), .full(q_full)
  );

  assign opc = head[OPC_LSB +: 6];

  always_comb begin
    pop = 1'b0; nxt_state = state;
    run_go = 1'b0; copy_go = 1'b0; setup_go = 1'b0;
    xdone_go = 1'b0; tbl_go = 1'b0; bad_go = 1'b0;
    if (!q_empty) begin
      if (state == S_OPND) begin
        pop = 1'b1;
        nxt_state = S_CMD;
        if (pend_copy) copy_go = 1'b1;
        else           setup_go = 1'b1;
      end else begin
        case (opc)
          OP_SETUP: begin pop = 1'b1; nxt_state = S_OPND; end
          OP_COPY:  if (!dma_busy) begin pop = 1'b1; nxt_state = S_OPND; end
          OP_START: if (!eng_busy) begin pop = 1'b1; run_go = 1'b1; end
          OP_XDONE: if (!eng_busy) begin pop = 1'b1; xdone_go = 1'b1; end
          OP_TABLE: if (!dma_busy) begin
            pop = 1'b1;
            if (head[KEY_ID_LSB + 3]) tbl_go = 1'b1;
            else                      bad_go = 1'b1;
          end
          default:  begin pop = 1'b1; bad_go = 1'b1; end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_CMD;
      pend_copy <= 1'b0;
      pend_hdr  <= '0;
    end else begin
      state <= nxt_state;
      if (state == S_CMD && nxt_state == S_OPND) begin
        pend_copy <= (opc == OP_COPY);
        pend_hdr  <= head[COPY_CNT_LSB +: HDR_W];
      end
    end
  end

  ccs_run_timer #(.CNT_W(CNT_W), .BLK_CYCLES(BLK_CYCLES)) u_run (
    .clk(clk), .rst(rst), .start(run_go), .blocks_m1(head[CNT_W-1:0]),
    .busy(eng_busy), .done(run_done)
  );

  ccs_copy_timer #(.WCNT_W(COPY_CNT_W)) u_copy (
    .clk(clk), .rst(rst), .start(copy_go), .words(pend_hdr[COPY_CNT_W-1:0]),
    .busy(dma_busy), .done(copy_done)
  );

  // action strobes and their fields
  always_ff @(posedge clk) begin
    if (rst) begin
      setup_stb <= 1'b0; run_stb <= 1'b0; xfer_done_stb <= 1'b0;
      tbl_stb <= 1'b0; copy_stb <= 1'b0;
      setup_addr <= '0; run_blocks_m1 <= '0; tbl_sel <= '0;
      tbl_ram_sel <= 1'b0; tbl_slot <= '0; copy_dir <= 1'b0;
      copy_words <= '0; copy_addr <= '0;
    end else begin
      setup_stb     <= setup_go;
      run_stb       <= run_go;
      xfer_done_stb <= xdone_go;
      tbl_stb       <= tbl_go;
      copy_stb      <= copy_go;
      if (setup_go) setup_addr <= head;
      if (run_go)   run_blocks_m1 <= head[CNT_W-1:0];
      if (tbl_go) begin
        tbl_sel     <= head[TBL_SEL_LSB +: 2];
        tbl_ram_sel <= head[TBL_RAM_BIT];
        tbl_slot    <= head[KEY_ID_LSB +: 3];
      end
      if (copy_go) begin
        copy_dir   <= pend_hdr[COPY_DIR_BIT - COPY_CNT_LSB];
        copy_words <= pend_hdr[COPY_CNT_W-1:0];
        copy_addr  <= head;
      end
    end
  end

  // interrupt status, write-one-to-clear, set wins over clear
  always_comb begin
    set_vec = '0;
    set_vec[IB_BADCMD] = bad_go;
    set_vec[IB_REJECT] = reject;
    set_vec[IB_RUN]    = run_done;
    set_vec[IB_COPY]   = copy_done;
    status_nxt = (int_status & ~(int_clr_wr ? int_clr_val : '0)) | set_vec;
    en_nxt     = int_en_wr ? int_en_val : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_status <= '0;
      en_q       <= '0;
      irq        <= 1'b0;
    end else begin
      int_status <= status_nxt;
      en_q       <= en_nxt;
      irq        <= |(status_nxt & en_nxt);
    end
  end

  p_reject_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && q_full) |=> int_status[IB_REJECT]);
  p_xdone_idle_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_done_stb |-> !eng_busy);
  p_bad_flag_r7: assert property (@(posedge clk) disable iff (rst)
    bad_go |=> int_status[IB_BADCMD]);
  p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
    (int_clr_wr && (&int_clr_val) && set_vec == '0) |=> int_status == '0);
  p_mask_off_r9: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/test_cipher_cmd_sequencer.sv
module test_cipher_cmd_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        int_en_wr = 1'b0, int_clr_wr = 1'b0;
  logic [7:0]  int_en_val = '0, int_clr_val = '0;
  logic [7:0]  int_status;
  logic        irq, eng_busy, q_empty, dma_busy;
  logic        setup_stb, run_stb, xfer_done_stb, tbl_stb, copy_stb;
  logic [31:0] setup_addr, copy_addr;
  logic [11:0] run_blocks_m1;
  logic [1:0]  tbl_sel;
  logic        tbl_ram_sel, copy_dir;
  logic [2:0]  tbl_slot;
  logic [12:0] copy_words;

  int n_chk = 0, n_fail = 0;
  int c_setup = 0, c_run = 0, c_xd = 0, c_tbl = 0, c_copy = 0;
  int c_ebusy = 0, c_dbusy = 0;

  always #4 clk = ~clk;

  cipher_cmd_sequencer i_cipher_cmd_sequencer (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .int_en_wr(int_en_wr), .int_en_val(int_en_val),
    .int_clr_wr(int_clr_wr), .int_clr_val(int_clr_val),
    .int_status(int_status), .irq(irq), .eng_busy(eng_busy),
    .q_empty(q_empty), .dma_busy(dma_busy),
    .setup_stb(setup_stb), .setup_addr(setup_addr),
    .run_stb(run_stb), .run_blocks_m1(run_blocks_m1),
    .xfer_done_stb(xfer_done_stb), .tbl_stb(tbl_stb), .tbl_sel(tbl_sel),
    .tbl_ram_sel(tbl_ram_sel), .tbl_slot(tbl_slot), .copy_stb(copy_stb),
    .copy_dir(copy_dir), .copy_words(copy_words), .copy_addr(copy_addr)
  );

  // event monitor: counts pulses and busy cycles seen at each edge
  always @(posedge clk) begin
    if (setup_stb)     c_setup <= c_setup + 1;
    if (run_stb)       c_run   <= c_run + 1;
    if (xfer_done_stb) c_xd    <= c_xd + 1;
    if (tbl_stb)       c_tbl   <= c_tbl + 1;
    if (copy_stb)      c_copy  <= c_copy + 1;
    if (eng_busy)      c_ebusy <= c_ebusy + 1;
    if (dma_busy)      c_dbusy <= c_dbusy + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input logic [7:0] v);
    @(negedge clk); int_en_wr = 1'b1; int_en_val = v;
    @(negedge clk); int_en_wr = 1'b0;
  endtask

  task automatic clr(input logic [7:0] v);
    @(negedge clk); int_clr_wr = 1'b1; int_clr_val = v;
    @(negedge clk); int_clr_wr = 1'b0;
  endtask

  function automatic logic [31:0] op(input logic [5:0] o);
    return {o, 26'h0};
  endfunction

  task automatic t_reset();
    check("R10 status", int_status, 0);
    check("R10 empty", q_empty, 1);
    check("R10 busy", {eng_busy, dma_busy}, 0);
    check("R10 irq", irq, 0);
  endtask

  task automatic t_setup();
    int s0 = c_setup, r0 = c_run;
    wr(op(6'h10)); wr(32'hDEAD_BEE0); idle(4);
    check("R2 setup count", c_setup - s0, 1);
    check("R2 setup addr", setup_addr, 32'hDEAD_BEE0);
    wr(op(6'h10)); wr(op(6'h0E) | 32'd5); idle(4);
    check("R2 operand not decoded", c_run - r0, 0);
    check("R2 operand addr", setup_addr, op(6'h0E) | 32'd5);
  endtask

  task automatic t_run();
    int b0, r0;
    set_en(8'h33);
    b0 = c_ebusy; r0 = c_run;
    wr(op(6'h0E) | 32'd2); idle(20);
    check("R3 run count", c_run - r0, 1);
    check("R3 blocks", run_blocks_m1, 2);
    check("R3 busy cycles", c_ebusy - b0, 12);
    check("R3 done bit", int_status[4], 1);
    check("R9 irq on done", irq, 1);
    clr(8'h10);
    check("R8 cleared bit", int_status[4], 0);
    check("R9 irq after clear", irq, 0);
  endtask

  task automatic t_xdone();
    int x0 = c_xd;
    clr(8'hFF);
    wr(op(6'h0E) | 32'd4); wr(op(6'h11)); idle(3);
    check("R4 held while busy", c_xd - x0, 0);
    check("R4 queued", q_empty, 0);
    wr(op(6'h11));
    check("R1 busy reject bit", int_status[1], 1);
    idle(30);
    check("R4 one pulse", c_xd - x0, 1);
  endtask

  task automatic t_copy();
    int c0 = c_copy, d0 = c_dbusy;
    clr(8'hFF);
    wr(op(6'h22) | (32'd1 << 25) | (32'd6 << 12)); wr(32'h8000_0100); idle(12);
    check("R5 copy count", c_copy - c0, 1);
    check("R5 dir", copy_dir, 1);
    check("R5 words", copy_words, 6);
    check("R5 addr", copy_addr, 32'h8000_0100);
    check("R5 busy cycles", c_dbusy - d0, 6);
    check("R5 done bit", int_status[5], 1);
    d0 = c_dbusy;
    wr(op(6'h22)); wr(32'h44); idle(6);
    check("R5 zero words", c_dbusy - d0, 1);
    check("R5 dir zero", copy_dir, 0);
  endtask

  task automatic t_table();
    int t0 = c_tbl;
    clr(8'hFF);
    wr(op(6'h15) | (32'd3 << 24) | (32'd1 << 23) | (32'd13 << 17)); idle(4);
    check("R6 load count", c_tbl - t0, 1);
    check("R6 sel", tbl_sel, 3);
    check("R6 ram sel", tbl_ram_sel, 1);
    check("R6 slot", tbl_slot, 5);
    wr(op(6'h15) | (32'd2 << 17)); idle(4);
    check("R6 bad id dropped", c_tbl - t0, 1);
    check("R6 bad id flag", int_status[0], 1);
  endtask

  task automatic t_unknown();
    int s0 = c_setup;
    clr(8'hFF);
    wr(op(6'h3F)); wr(op(6'h10)); wr(32'h1234_5678); idle(4);
    check("R7 error bit", int_status[0], 1);
    check("R7 next runs", c_setup - s0, 1);
    check("R7 next addr", setup_addr, 32'h1234_5678);
  endtask

  task automatic t_full();
    int t0 = c_tbl;
    clr(8'hFF);
    wr(op(6'h22) | (32'd40 << 12)); wr(32'h900);
    for (int i = 0; i < 5; i++) wr(op(6'h15) | (32'd8 << 17));
    check("R1 queue holds", q_empty, 0);
    check("R1 no flag yet", int_status[1], 0);
    wr(op(6'h15) | (32'd8 << 17));
    check("R1 full reject bit", int_status[1], 1);
    idle(60);
    check("R1 five drained", c_tbl - t0, 5);
    check("R1 empty after", q_empty, 1);
  endtask

  task automatic t_mask();
    clr(8'hFF);
    set_en(8'h00);
    wr(op(6'h2A)); idle(2);
    check("R9 masked status", int_status[0], 1);
    check("R9 masked irq", irq, 0);
    set_en(8'h33);
    check("R9 enabled irq", irq, 1);
    clr(8'hFF);
    check("R8 clear all", int_status, 0);
    check("R8 irq low", irq, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_setup();
    t_run();
    t_xdone();
    t_copy();
    t_table();
    t_unknown();
    t_full();
    t_mask();
    finish_run();
  end
endmodule